// File: doc/BRIEF.md
# Framed Serial Transmitter with Underflow Repeat

This block turns words written by a host into a single serial bit stream. A word goes first into a one-entry holding buffer. When a frame-sync pulse arrives, the block moves the buffered word into a shift register. It then drives the word onto the serial pin most significant bit first, one bit for each falling edge of the bit clock. The bit clock is not used as a clock inside the block. It arrives as `bitTick`, a single-cycle strobe in the system clock domain that marks each falling edge. `frameSync` is sampled only in cycles where `bitTick` is high.

If a frame starts while the buffer is empty, the block sends the last word it sent again. It keeps doing this on every frame until the host supplies a new word. A frame sync that arrives while a word is still being shifted out is ignored, but it is recorded. A write into a full buffer is rejected and recorded. Three sticky error flags are cleared by writing 1 to them, and a mask selects which flags pull the active-low interrupt line low. A one-cycle request strobe tells a DMA engine or the host when the buffer has been emptied.

Top module: `ser_tx_top`

## Requirements
- R1: After reset, `serOut` is 0, `bufHasData` is 0, `txReq` is 0, `errFlags` is 0 and `irqN` is 1.
- R2: A host write to an empty buffer stores the word and sets `bufHasData` to 1. A frame sync with data buffered drives bit WORD_W-1 on `serOut` after that tick. Each later tick drives the next lower bit, so the word goes out MSB first over WORD_W ticks.
- R3: The tick after the last bit of a word drives `serOut` back to 0 when no new frame starts on it. The pin then stays 0 until a frame starts.
- R4: Moving the buffered word into the shifter clears `bufHasData` and raises `txReq` for exactly one cycle.
- R5: A frame sync that finds the buffer empty sends the previously sent word again, MSB first, and sets `errFlags[0]` (underflow). Before any word has been sent, the repeated word is all zeros.
- R6: The repeat of R5 happens on every following frame sync until a host write fills the buffer. The next frame then sends the new word.
- R7: A frame sync that arrives while bits of the current word remain to be sent is ignored. The word keeps shifting bit by bit, and `errFlags[2]` (sync error) is set.
- R8: A host write while the buffer is full sets `errFlags[1]` (overflow) and discards the written word. The buffered word is the one sent next.
- R9: Writing 1 to a bit of `flagClr` clears the matching flag. When a flag is set and cleared in the same cycle, the set wins.
- R10: `irqN` is 0 exactly when some flag is 1 and its `irqMask` bit (same bit position) is 1. Otherwise it is 1.
- R11: A frame sync on the tick right after the last bit of a word starts the next word on that tick, with no idle bit and no sync error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle strobe marking a falling bit-clock edge |
| frameSync | input | 1 | Frame-sync level, sampled when bitTick is 1 |
| hostWr | input | 1 | Host write strobe into the transmit buffer |
| hostData | input | WORD_W | Word written by the host |
| flagClr | input | 3 | Write-1-to-clear strobes for the error flags |
| irqMask | input | 3 | Interrupt enable per error flag |
| serOut | output | 1 | Serial data pin, idles low |
| bufHasData | output | 1 | 1 while the buffer holds a word, 0 when empty |
| txReq | output | 1 | One-cycle pulse when the buffer empties into the shifter |
| errFlags | output | 3 | Sticky flags: [0] underflow, [1] overflow, [2] sync error |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `bitTick` is a clean single-cycle strobe and that `frameSync` matters only while it is high. They also assume that host writes and clears are single-cycle strobes, so a word counts as sent only on tick cycles. The stimulus raises `bitTick` for one cycle and then leaves at least one idle cycle before the next tick. It changes `frameSync` only together with a tick, and it applies writes and clears away from ticks, except where a case deliberately makes two events coincide. Each tick pushes the expected pin, request and buffer state into a queue, and these are compared after the edge at which the registers update.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  localparam int NUM_FLAGS = 3;
  localparam int FLAG_UNDER = 0;
  localparam int FLAG_OVER  = 1;
  localparam int FLAG_SYNC  = 2;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic writeBuf;  // capture hostData into the buffer
    logic loadBuf;   // move buffer word into the shifter
    logic loadRep;   // reload the last sent word into the shifter
    logic shiftBit;  // put out the next bit of the current word
    logic endWord;   // word complete, drive the idle level
  } txStrobes_t;

endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 frameSync,
  input  logic                 hostWr,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic [NUM_FLAGS-1:0] irqMask,
  output txStrobes_t           strobes,
  output logic                 bufHasData,
  output logic                 txReq,
  output logic [NUM_FLAGS-1:0] errFlags,
  output logic                 irqN
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic             bufValid;
  logic             active;
  logic [CNT_W-1:0] bitCnt;
  logic [NUM_FLAGS-1:0] flagSet;

  logic busy;
  logic syncTick;
  logic startFrame;
  logic syncErr;
  logic overflow;

  // A word is in flight while fewer than WORD_W bits have been driven.
  assign busy       = active && (bitCnt < FULL_CNT);
  assign syncTick   = bitTick && frameSync;
  assign startFrame = syncTick && !busy;
  assign syncErr    = syncTick && busy;

  always_comb begin
    strobes          = '0;
    strobes.loadBuf  = startFrame && bufValid;
    strobes.loadRep  = startFrame && !bufValid;
    strobes.shiftBit = bitTick && busy;
    strobes.endWord  = bitTick && active && !busy && !startFrame;
    strobes.writeBuf = hostWr && (!bufValid || strobes.loadBuf);
  end

  assign overflow = hostWr && bufValid && !strobes.loadBuf;

  always_comb begin
    flagSet             = '0;
    flagSet[FLAG_UNDER] = strobes.loadRep;
    flagSet[FLAG_OVER]  = overflow;
    flagSet[FLAG_SYNC]  = syncErr;
  end

  // Buffer occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid <= 1'b0;
    end else if (strobes.writeBuf) begin
      bufValid <= 1'b1;
    end else if (strobes.loadBuf) begin
      bufValid <= 1'b0;
    end
  end

  // Bit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (strobes.loadBuf || strobes.loadRep) begin
      active <= 1'b1;
      bitCnt <= CNT_W'(1);
    end else if (strobes.shiftBit) begin
      bitCnt <= bitCnt + 1'b1;
    end else if (strobes.endWord) begin
      active <= 1'b0;
      bitCnt <= '0;
    end
  end

  // Sticky flags, set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlags <= '0;
    end else begin
      for (int i = 0; i < NUM_FLAGS; i++) begin
        if (flagSet[i]) begin
          errFlags[i] <= 1'b1;
        end else if (flagClr[i]) begin
          errFlags[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReq <= 1'b0;
    end else begin
      txReq <= strobes.loadBuf;
    end
  end

  assign bufHasData = bufValid;
  assign irqN       = ~|(errFlags & irqMask);

  AST_OVERFLOW_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> (bufValid && errFlags[FLAG_OVER])) else $error("overflow handling"); // R8

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRep |=> (errFlags[FLAG_UNDER] && active)) else $error("underflow flag"); // R5

  AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> (active && bitCnt == $past(bitCnt) + 1'b1 && errFlags[FLAG_SYNC])) else $error("sync not ignored"); // R7

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadBuf, strobes.loadRep, strobes.shiftBit, strobes.endWord})) else $error("conflicting strobes"); // R11

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(errFlags[FLAG_SYNC]) && irqMask[FLAG_SYNC]) |-> !irqN) else $error("irq not raised"); // R10

  AST_REQ_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadBuf && !hostWr) |=> (txReq && !bufValid)) else $error("request pulse"); // R4

endmodule

// File: rtl/ser_tx_datapath.sv
module ser_tx_datapath
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [WORD_W-1:0] hostData,
  output logic              serOut
);

  logic [WORD_W-1:0] bufData;
  logic [WORD_W-1:0] lastWord;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
    end else if (strobes.writeBuf) begin
      bufData <= hostData;
    end
  end

  // Copy of the word most recently started, used for underflow repeats.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWord <= '0;
    end else if (strobes.loadBuf) begin
      lastWord <= bufData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      serOut   <= 1'b0;
    end else if (strobes.loadBuf) begin
      serOut   <= bufData[WORD_W-1];
      shiftReg <= {bufData[WORD_W-2:0], 1'b0};
    end else if (strobes.loadRep) begin
      serOut   <= lastWord[WORD_W-1];
      shiftReg <= {lastWord[WORD_W-2:0], 1'b0};
    end else if (strobes.shiftBit) begin
      serOut   <= shiftReg[WORD_W-1];
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end else if (strobes.endWord) begin
      serOut   <= 1'b0;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.endWord |=> !serOut) else $error("pin not idle"); // R3

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadBuf || strobes.loadRep || strobes.shiftBit || strobes.endWord) |=> $stable(serOut)) else $error("pin moved"); // R2

  AST_REPEAT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRep |=> (serOut == $past(lastWord[WORD_W-1]))) else $error("repeat word"); // R5

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              frameSync,
  input  logic              hostWr,
  input  logic [WORD_W-1:0] hostData,
  input  logic [2:0]        flagClr,
  input  logic [2:0]        irqMask,
  output logic              serOut,
  output logic              bufHasData,
  output logic              txReq,
  output logic [2:0]        errFlags,
  output logic              irqN
);

  txStrobes_t strobes;

  ser_tx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .frameSync  (frameSync),
    .hostWr     (hostWr),
    .flagClr    (flagClr),
    .irqMask    (irqMask),
    .strobes    (strobes),
    .bufHasData (bufHasData),
    .txReq      (txReq),
    .errFlags   (errFlags),
    .irqN       (irqN)
  );

  ser_tx_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .hostData (hostData),
    .serOut   (serOut)
  );

endmodule

// File: tb/ser_tx_top_bench.sv
module ser_tx_top_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bitTick = 1'b0;
  logic         frameSync = 1'b0;
  logic         hostWr = 1'b0;
  logic [W-1:0] hostData = '0;
  logic [2:0]   flagClr = '0;
  logic [2:0]   irqMask = '0;
  logic         serOut;
  logic         bufHasData;
  logic         txReq;
  logic [2:0]   errFlags;
  logic         irqN;

  always #2.5 clk = ~clk;

  ser_tx_top #(.WORD_W(W)) u_ser_tx_top (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameSync(frameSync),
    .hostWr(hostWr), .hostData(hostData), .flagClr(flagClr), .irqMask(irqMask),
    .serOut(serOut), .bufHasData(bufHasData), .txReq(txReq),
    .errFlags(errFlags), .irqN(irqN)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [W-1:0] mBuf = '0;
  logic         mBufValid = 1'b0;
  logic [W-1:0] mLast = '0;
  logic [W-1:0] mWord = '0;
  logic         mActive = 1'b0;
  int           mCnt = 0;
  logic [2:0]   mFlags = '0;

  // Expected {bufHasData, txReq, serOut} after each tick, plus requirement tag
  logic [2:0] expQ[$];
  string      tagQ[$];
  logic       tickSeen = 1'b0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per tick and compares after the edge.
  always @(posedge clk) tickSeen <= bitTick;
  always @(negedge clk) begin
    if (tickSeen) begin
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R2 actual=tick expected=no tick");
      end else begin
        check(tagQ.pop_front(), {13'd0, bufHasData, txReq, serOut}, {13'd0, expQ.pop_front()});
      end
    end
  end

  // Driver: one bit-clock falling edge, optional frame sync.
  task automatic tick(input logic sync, input string tag);
    logic busy;
    logic req;
    logic pin;
    busy = mActive && (mCnt < W);
    req = 1'b0;
    if (sync && busy) mFlags[2] = 1'b1;
    if (sync && !busy) begin
      if (mBufValid) begin
        mWord = mBuf; mLast = mBuf; mBufValid = 1'b0; req = 1'b1;
      end else begin
        mWord = mLast; mFlags[0] = 1'b1;
      end
      mActive = 1'b1; mCnt = 1; pin = mWord[W-1];
    end else if (busy) begin
      pin = mWord[W-1-mCnt]; mCnt++;
    end else begin
      pin = 1'b0; mActive = 1'b0; mCnt = 0;
    end
    @(negedge clk);
    bitTick = 1'b1; frameSync = sync;
    expQ.push_back({mBufValid, req, pin});
    tagQ.push_back(tag);
    @(negedge clk);
    bitTick = 1'b0; frameSync = 1'b0;
  endtask

  task automatic frame(input string tag);
    tick(1'b1, tag);
    for (int i = 1; i < W; i++) tick(1'b0, tag);
  endtask

  task automatic hostWrite(input logic [W-1:0] d, input logic [2:0] clr);
    @(negedge clk);
    hostWr = 1'b1; hostData = d; flagClr = clr;
    mFlags = mFlags & ~clr;
    if (mBufValid) mFlags[1] = 1'b1;
    else begin mBuf = d; mBufValid = 1'b1; end
    @(negedge clk);
    hostWr = 1'b0; flagClr = '0;
  endtask

  task automatic clearFlags(input logic [2:0] clr);
    @(negedge clk);
    flagClr = clr; mFlags = mFlags & ~clr;
    @(negedge clk);
    flagClr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 serOut", {15'd0, serOut}, 16'd0);
    check("R1 bufHasData", {15'd0, bufHasData}, 16'd0);
    check("R1 txReq", {15'd0, txReq}, 16'd0);
    check("R1 errFlags", {13'd0, errFlags}, 16'd0);
    check("R1 irqN", {15'd0, irqN}, 16'd1);

    // R2 store and serialise
    hostWrite(16'hA5C3, 3'b000);
    check("R2 bufHasData", {15'd0, bufHasData}, 16'd1);
    frame("R2 R4 word out");
    // R3 idle low after last bit
    tick(1'b0, "R3 idle");
    tick(1'b0, "R3 idle hold");
    check("R3 no flags", {13'd0, errFlags}, {13'd0, mFlags});

    // R5 underflow repeat, R11 back-to-back, R6 repeat every frame
    frame("R5 repeat");
    check("R5 underflow flag", {13'd0, errFlags}, {13'd0, mFlags});
    frame("R11 R6 back-to-back repeat");
    check("R11 no sync error", {15'd0, errFlags[2]}, 16'd0);
    hostWrite(16'h1234, 3'b000);
    // R7 mid-word sync while sending the new word (R6 ends repeat)
    tick(1'b1, "R6 new word");
    for (int i = 1; i < W; i++) tick(i == 5, "R7 continue");
    check("R7 sync flag", {13'd0, errFlags}, {13'd0, mFlags});
    tick(1'b0, "R3 idle");

    // R10 interrupt masking
    irqMask = 3'b010;
    @(negedge clk);
    check("R10 masked", {15'd0, irqN}, 16'd1);
    irqMask = 3'b100;
    @(negedge clk);
    check("R10 enabled", {15'd0, irqN}, 16'd0);
    clearFlags(3'b100);
    check("R9 clear sync", {13'd0, errFlags}, {13'd0, mFlags});
    check("R10 released", {15'd0, irqN}, 16'd1);
    clearFlags(3'b001);
    check("R9 clear under", {13'd0, errFlags}, {13'd0, mFlags});

    // R8 overflow discards the second write; R9 set wins over clear
    hostWrite(16'h8001, 3'b000);
    hostWrite(16'h7FFE, 3'b010);
    check("R8 R9 overflow flag", {13'd0, errFlags}, {13'd0, mFlags});
    irqMask = 3'b010;
    @(negedge clk);
    check("R10 overflow irq", {15'd0, irqN}, 16'd0);
    frame("R8 kept word");
    tick(1'b0, "R3 idle");
    clearFlags(3'b111);
    check("R9 all cleared", {13'd0, errFlags}, 16'd0);
    check("R10 idle irq", {15'd0, irqN}, 16'd1);

    repeat (4) @(negedge clk);
    check("R2 queue drained", 16'(expQ.size()), 16'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule